// File: doc/BRIEF.md
# Fixed-Point RGB to YCbCr Pixel Converter

This block turns a stream of 8-bit red, green and blue samples into 8-bit luma (Y) and two chroma components (U, V). It accepts one pixel per clock, flagged by an input valid, with no back-pressure. Each component is a weighted sum of the three inputs using integer weights scaled by 2^13. The sum is floored by an arithmetic right shift of 13 bits and then offset: +16 for luma (studio range) and +128 for both chroma channels.

The work is split into three register stages: products, signed sums, then shift, offset and saturation to 0..255. The output valid is the input valid delayed by the same three stages. Output data registers load only on a valid pixel and hold their value otherwise.

Top module: `rgb2ycc_conv`

## Requirements
- R1: When a pixel's result is presented, out_y equals 16 + floor((2104·R + 4130·G + 802·B) / 8192).
- R2: out_u equals 128 + floor((3598·B − 1217·R − 2382·G) / 8192). The sum is signed, so a negative sum rounds toward minus infinity.
- R3: out_v equals 128 + floor((3598·R − 3015·G − 583·B) / 8192), with the same signed flooring.
- R4: A pixel presented with in_valid high in one cycle has its result on the outputs, with out_valid high, three rising edges later. A cycle with in_valid low produces out_valid low three edges later.
- R5: While rst is high at a rising edge, the next cycle shows out_valid low and out_y, out_u, out_v all zero. For the first three cycles after reset is released, out_valid stays low.
- R6: When out_valid is low, out_y, out_u and out_v keep the values of the last result presented (zero if none has been presented since reset).
- R7: Every result is saturated to 0..255. Black (0,0,0) gives (16,128,128). White (255,255,255) gives (235,127,128).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel qualifier |
| in_r | input | 8 | Red sample, unsigned |
| in_g | input | 8 | Green sample, unsigned |
| in_b | input | 8 | Blue sample, unsigned |
| out_valid | output | 1 | Result qualifier, in_valid delayed three cycles |
| out_y | output | 8 | Luma result |
| out_u | output | 8 | Blue-difference chroma result |
| out_v | output | 8 | Red-difference chroma result |

## Verification
The range properties assume that each input component is an unsigned 8-bit value. Under that assumption luma stays within 16..235, U within 15..240 and V within 16..240. The stimulus respects this by construction, since it drives the byte-wide ports directly: mostly $urandom values from a fixed seed, plus directed pixels at black, white, the pure primaries and the two chroma extremes. The in_valid input is also randomly dropped, so that the hold behaviour is exercised between results.

// File: rtl/rgb2ycc_pkg.sv
package rgb2ycc_pkg;
    localparam int PIX_W  = 8;
    localparam int FRAC_W = 13;
    localparam int ACC_W  = 24;
    localparam int NCH    = 3;

    localparam logic signed [ACC_W-1:0] K_YR = 24'sd2104;
    localparam logic signed [ACC_W-1:0] K_YG = 24'sd4130;
    localparam logic signed [ACC_W-1:0] K_YB = 24'sd802;
    localparam logic signed [ACC_W-1:0] K_UR = 24'sd1217;
    localparam logic signed [ACC_W-1:0] K_UG = 24'sd2382;
    localparam logic signed [ACC_W-1:0] K_UB = 24'sd3598;
    localparam logic signed [ACC_W-1:0] K_VR = 24'sd3598;
    localparam logic signed [ACC_W-1:0] K_VG = 24'sd3015;
    localparam logic signed [ACC_W-1:0] K_VB = 24'sd583;

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic [PIX_W-1:0] r;
        logic [PIX_W-1:0] g;
        logic [PIX_W-1:0] b;
    } pix_t;

    typedef struct packed {
        acc_t yr, yg, yb;
        acc_t ur, ug, ub;
        acc_t vr, vg, vb;
    } prod_t;

    function automatic acc_t widen(input logic [PIX_W-1:0] c);
        return acc_t'({{(ACC_W-PIX_W){1'b0}}, c});
    endfunction

    function automatic logic [PIX_W-1:0] sat_pix(input acc_t x);
        if (x < 0)
            return '0;
        else if (x > acc_t'((1 << PIX_W) - 1))
            return '1;
        else
            return x[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/rgb2ycc_mul.sv
module rgb2ycc_mul
    import rgb2ycc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld_i,
    input  pix_t  pix_i,
    output logic  vld_o,
    output prod_t prod_o
);
    acc_t r_w, g_w, b_w;

    always_comb begin
        r_w = widen(pix_i.r);
        g_w = widen(pix_i.g);
        b_w = widen(pix_i.b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            prod_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                prod_o.yr <= r_w * K_YR;
                prod_o.yg <= g_w * K_YG;
                prod_o.yb <= b_w * K_YB;
                prod_o.ur <= r_w * K_UR;
                prod_o.ug <= g_w * K_UG;
                prod_o.ub <= b_w * K_UB;
                prod_o.vr <= r_w * K_VR;
                prod_o.vg <= g_w * K_VG;
                prod_o.vb <= b_w * K_VB;
            end
        end
    end
endmodule

// File: rtl/rgb2ycc_sum.sv
module rgb2ycc_sum
    import rgb2ycc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld_i,
    input  prod_t prod_i,
    output logic  vld_o,
    output acc_t  sum_o [NCH]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            for (int i = 0; i < NCH; i++) sum_o[i] <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                sum_o[0] <= prod_i.yr + prod_i.yg + prod_i.yb;
                sum_o[1] <= prod_i.ub - prod_i.ur - prod_i.ug;
                sum_o[2] <= prod_i.vr - prod_i.vg - prod_i.vb;
            end
        end
    end
endmodule

// File: rtl/rgb2ycc_norm.sv
module rgb2ycc_norm
    import rgb2ycc_pkg::*;
#(
    parameter int OFFSET = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  acc_t             sum_i,
    output logic [PIX_W-1:0] pix_o
);
    acc_t scaled;

    always_comb scaled = (sum_i >>> FRAC_W) + acc_t'(OFFSET);

    always_ff @(posedge clk) begin
        if (rst)
            pix_o <= '0;
        else if (vld_i)
            pix_o <= sat_pix(scaled);
    end
endmodule

// File: rtl/rgb2ycc_conv.sv
module rgb2ycc_conv
    import rgb2ycc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_r,
    input  logic [PIX_W-1:0] in_g,
    input  logic [PIX_W-1:0] in_b,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_y,
    output logic [PIX_W-1:0] out_u,
    output logic [PIX_W-1:0] out_v
);
    localparam int OFS [NCH] = '{16, 128, 128};

    pix_t             pix_in;
    prod_t            prod_q;
    logic             vld_p, vld_s;
    acc_t             sum_q [NCH];
    logic [PIX_W-1:0] res [NCH];

    always_comb begin
        pix_in.r = in_r;
        pix_in.g = in_g;
        pix_in.b = in_b;
    end

    rgb2ycc_mul u_mul (
        .clk(clk), .rst(rst), .vld_i(in_valid), .pix_i(pix_in),
        .vld_o(vld_p), .prod_o(prod_q)
    );

    rgb2ycc_sum u_sum (
        .clk(clk), .rst(rst), .vld_i(vld_p), .prod_i(prod_q),
        .vld_o(vld_s), .sum_o(sum_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rgb2ycc_norm #(.OFFSET(OFS[c])) u_norm (
            .clk(clk), .rst(rst), .vld_i(vld_s), .sum_i(sum_q[c]),
            .pix_o(res[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= vld_s;
    end

    assign out_y = res[0];
    assign out_u = res[1];
    assign out_v = res[2];
endmodule

// File: rtl/rgb2ycc_conv_chk.sv
module rgb2ycc_conv_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       out_valid,
    input logic [7:0] out_y,
    input logic [7:0] out_u,
    input logic [7:0] out_v
);
    logic [1:0] since_rst;
    logic [2:0] vhist;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            vhist     <= '0;
        end else begin
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            vhist <= {vhist[1:0], in_valid};
        end
    end

    // R4: valid delayed by three stages
    p_valid_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == vhist[2]));

    // R5: reset clears the outputs
    p_reset_clear_r5: assert property (@(posedge clk)
        rst |=> (!out_valid && out_y == 8'd0 && out_u == 8'd0 && out_v == 8'd0));

    // R6: data held while no result is presented
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |=> (!out_valid -> ($stable(out_y) && $stable(out_u) && $stable(out_v))));

    // R1: luma stays in studio range
    p_luma_range_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_y >= 8'd16 && out_y <= 8'd235));

    // R2: U within its reachable span
    p_u_range_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_u >= 8'd15 && out_u <= 8'd240));

    // R3: V within its reachable span
    p_v_range_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_v >= 8'd16 && out_v <= 8'd240));
endmodule

bind rgb2ycc_conv rgb2ycc_conv_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_y(out_y), .out_u(out_u), .out_v(out_v)
);

// File: tb/rgb2ycc_conv_tb.sv
`timescale 1ns/1ps
module rgb2ycc_conv_tb;
    localparam int NVEC = 3000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_valid;
    logic [7:0] out_y, out_u, out_v;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic       hv [NVEC];
    logic [7:0] hr [NVEC];
    logic [7:0] hg [NVEC];
    logic [7:0] hb [NVEC];

    always #2.5 clk = ~clk;

    rgb2ycc_conv u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v)
    );

    function automatic int fsat(input int x);
        if (x < 0) return 0;
        if (x > 255) return 255;
        return x;
    endfunction

    function automatic int exp_y(input int r, input int g, input int b);
        return fsat(16 + ((2104*r + 4130*g + 802*b) >>> 13));
    endfunction

    function automatic int exp_u(input int r, input int g, input int b);
        return fsat(128 + ((3598*b - 1217*r - 2382*g) >>> 13));
    endfunction

    function automatic int exp_v(input int r, input int g, input int b);
        return fsat(128 + ((3598*r - 3015*g - 583*b) >>> 13));
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    int ly = 0, lu = 0, lv = 0;

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int i = 0; i < NVEC; i++) begin
            hv[i] = ($urandom % 4) != 0;
            hr[i] = 8'($urandom);
            hg[i] = 8'($urandom);
            hb[i] = 8'($urandom);
        end
        // directed corners (R7: black, white; primaries; chroma extremes)
        hv[0] = 1; hr[0] = 0;   hg[0] = 0;   hb[0] = 0;
        hv[1] = 1; hr[1] = 255; hg[1] = 255; hb[1] = 255;
        hv[2] = 1; hr[2] = 255; hg[2] = 0;   hb[2] = 0;
        hv[3] = 1; hr[3] = 0;   hg[3] = 255; hb[3] = 0;
        hv[4] = 1; hr[4] = 0;   hg[4] = 0;   hb[4] = 255;
        hv[5] = 0; hr[5] = 9;   hg[5] = 9;   hb[5] = 9;
        hv[6] = 1; hr[6] = 255; hg[6] = 255; hb[6] = 0;
        hv[7] = 1; hr[7] = 0;   hg[7] = 255; hb[7] = 255;
        hv[8] = 1; hr[8] = 1;   hg[8] = 1;   hb[8] = 1;

        repeat (4) @(negedge clk);
        // R5: reset state
        check("R5 out_valid in reset", int'(out_valid), 0);
        check("R5 out_y in reset", int'(out_y), 0);
        check("R5 out_u in reset", int'(out_u), 0);
        check("R5 out_v in reset", int'(out_v), 0);
        rst = 1'b0;

        for (int j = 0; j < NVEC + 3; j++) begin
            if (j < 3) begin
                check("R5 out_valid low after reset", int'(out_valid), 0);
            end else if (hv[j-3]) begin
                int r, g, b;
                r = hr[j-3]; g = hg[j-3]; b = hb[j-3];
                ly = exp_y(r, g, b); lu = exp_u(r, g, b); lv = exp_v(r, g, b);
                check("R4 out_valid", int'(out_valid), 1);
                check("R1 out_y", int'(out_y), ly);
                check("R2 out_u", int'(out_u), lu);
                check("R3 out_v", int'(out_v), lv);
                if (j - 3 == 0) begin
                    check("R7 black y", int'(out_y), 16);
                    check("R7 black u", int'(out_u), 128);
                    check("R7 black v", int'(out_v), 128);
                end
                if (j - 3 == 1) begin
                    check("R7 white y", int'(out_y), 235);
                    check("R7 white u", int'(out_u), 127);
                    check("R7 white v", int'(out_v), 128);
                end
            end else begin
                check("R4 out_valid idle", int'(out_valid), 0);
                check("R6 hold y", int'(out_y), ly);
                check("R6 hold u", int'(out_u), lu);
                check("R6 hold v", int'(out_v), lv);
            end
            if (j < NVEC) begin
                in_valid = hv[j]; in_r = hr[j]; in_g = hg[j]; in_b = hb[j];
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule